// File: doc/BRIEF.md
# Infrared Serial Port Interrupt Identification

This block decides which interrupt a legacy-mode infrared serial port reports and when it goes away. It watches the receive error flags, the receive-data and FIFO trigger levels, the receive FIFO occupancy with a character-time tick, and the transmit-holding-empty flag. Of the pending sources it encodes only the most urgent into the low nibble of an 8-bit read-only status word. It raises an interrupt request whenever anything is pending and the master output enable is set.

Each source is cleared by the bus access that services it. A line status read clears receive errors. A receive buffer read clears the time-out. A transmit buffer write clears transmit-empty. A status read also clears transmit-empty, but only when that is the code being shown. A character time-out counter runs in FIFO mode while the receive FIFO holds data. It restarts on every FIFO push or pop and flags a time-out after a fixed number of character times.

Top module: `irda_int_ident`

## Requirements
- R1: Status bits 7 and 6 both equal the FIFO-enable input; bits 5 and 4 always read 0; the active code is in bits 3:0.
- R2: After reset, with FIFO mode off, the status reads 0x01 and the interrupt request is low.
- R3: A pulse on overrun, parity, missing-stop or break sets a sticky receive-status source, code 0110, which has top priority; a line status read clears it unless a new error arrives in the same cycle.
- R4: Received-data source, code 0100, follows the trigger-level input in FIFO mode and the data-ready input otherwise; it ranks above time-out and transmit-empty.
- R5: Time-out, code 1100, is set in FIFO mode with a non-empty receive FIFO once 4 character ticks have elapsed without a FIFO push or pop; a receive buffer read, an empty FIFO or FIFO mode off clears it; it is never shown with FIFO mode off.
- R6: The character counter restarts on each receive buffer read or FIFO push and is held at zero while the FIFO is empty or FIFO mode is off.
- R7: Transmit-empty, code 0010, is set on a rising edge of the transmit-holding-empty input (not by its level after reset) and cleared by a transmit buffer write.
- R8: A status read clears transmit-empty only when 0010 is the code being reported in that cycle; otherwise it leaves it pending.
- R9: A lower-priority source stays pending while a higher one is reported and appears once the higher one clears.
- R10: With nothing pending the code is 0001; the interrupt request equals the output enable AND NOT status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| overrunErr | input | 1 | Receive overrun event pulse |
| parityErr | input | 1 | Parity error event pulse |
| stopErr | input | 1 | Missing stop bit event pulse |
| breakDet | input | 1 | Break detected event pulse |
| rxDataReady | input | 1 | Receive data ready level (non-FIFO mode) |
| fifoTrigHit | input | 1 | Receive FIFO at or above trigger level |
| rxNotEmpty | input | 1 | Receive FIFO holds data |
| charTick | input | 1 | One pulse per character time |
| txEmpty | input | 1 | Transmit holding register empty |
| fifoEn | input | 1 | FIFO mode enable |
| irqEn | input | 1 | Master interrupt output enable |
| isrRead | input | 1 | Status register read strobe |
| lsrRead | input | 1 | Line status register read strobe |
| rbrRead | input | 1 | Receive buffer read strobe (FIFO pop) |
| thrWrite | input | 1 | Transmit buffer write strobe |
| rxPush | input | 1 | Receive FIFO write strobe |
| isrValue | output | 8 | Interrupt status word |
| irqOut | output | 1 | Interrupt request |

## Verification
Every cycle, the assertions check the fixed status bits and the request gating. They also check that the time-out code never shows outside FIFO mode, that an error pulse shows receive status on the next cycle, and that each servicing access removes its own code. The order in which the sources rank against each other, whether a masked source is kept, the exact tick count of the time-out and the restart on push or pop need multi-cycle scenarios. The bench covers these with directed sequences and a random run checked against its own model.

// File: rtl/irda_iid_pkg.sv
package irda_iid_pkg;

  typedef enum logic [3:0] {
    CODE_NONE    = 4'b0001,
    CODE_TXEMPTY = 4'b0010,
    CODE_RXDATA  = 4'b0100,
    CODE_RXSTAT  = 4'b0110,
    CODE_TMO     = 4'b1100
  } iidCode_e;

  typedef struct packed {
    logic clrRxStat;
    logic clrTimeout;
    logic clrTxEmpty;
    logic rstTimer;
  } iidStrobes_t;

endpackage

// File: rtl/irda_iid_ctrl.sv
module irda_iid_ctrl
  import irda_iid_pkg::*;
(
  input  logic        isrRead,
  input  logic        lsrRead,
  input  logic        rbrRead,
  input  logic        thrWrite,
  input  logic        rxPush,
  input  iidCode_e    curCode,
  output iidStrobes_t strb
);

  always_comb begin
    strb            = '0;
    strb.clrRxStat  = lsrRead;
    strb.clrTimeout = rbrRead;
    strb.rstTimer   = rbrRead | rxPush;
    // transmit-empty is acknowledged by a status read only while it is on show
    strb.clrTxEmpty = thrWrite | (isrRead && (curCode == CODE_TXEMPTY));
  end

endmodule

// File: rtl/irda_iid_dp.sv
module irda_iid_dp
  import irda_iid_pkg::*;
#(
  parameter int TO_CHARS = 4,
  localparam int CNT_W   = $clog2(TO_CHARS + 1)
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  errPulse,
  input  logic        rxDataReady,
  input  logic        fifoTrigHit,
  input  logic        rxNotEmpty,
  input  logic        charTick,
  input  logic        txEmpty,
  input  logic        fifoEn,
  input  iidStrobes_t strb,
  output iidCode_e    curCode,
  output logic [7:0]  isrValue
);

  logic             rxStatPend;
  logic             tmoPend;
  logic             txEmptyPend;
  logic             txEmptyDly;
  logic [CNT_W-1:0] charCnt;
  logic             timerIdle;
  logic             txRise;
  logic             rxDataPend;
  logic             tmoActive;

  assign timerIdle  = !fifoEn || !rxNotEmpty;
  assign txRise     = txEmpty && !txEmptyDly;
  assign rxDataPend = fifoEn ? fifoTrigHit : rxDataReady;
  assign tmoActive  = tmoPend && fifoEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxStatPend <= 1'b0;
    end else if (|errPulse) begin
      rxStatPend <= 1'b1;
    end else if (strb.clrRxStat) begin
      rxStatPend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      charCnt <= '0;
    end else if (timerIdle || strb.rstTimer) begin
      charCnt <= '0;
    end else if (charTick && (charCnt != CNT_W'(TO_CHARS))) begin
      charCnt <= charCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmoPend <= 1'b0;
    end else if (timerIdle || strb.clrTimeout) begin
      tmoPend <= 1'b0;
    end else if (charTick && !strb.rstTimer
                 && (charCnt == CNT_W'(TO_CHARS - 1))) begin
      tmoPend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEmptyDly  <= 1'b1;
      txEmptyPend <= 1'b0;
    end else begin
      txEmptyDly <= txEmpty;
      if (txRise) begin
        txEmptyPend <= 1'b1;
      end else if (strb.clrTxEmpty) begin
        txEmptyPend <= 1'b0;
      end
    end
  end

  always_comb begin
    if (rxStatPend)       curCode = CODE_RXSTAT;
    else if (rxDataPend)  curCode = CODE_RXDATA;
    else if (tmoActive)   curCode = CODE_TMO;
    else if (txEmptyPend) curCode = CODE_TXEMPTY;
    else                  curCode = CODE_NONE;
  end

  assign isrValue = {fifoEn, fifoEn, 2'b00, curCode};

endmodule

// File: rtl/irda_int_ident.sv
module irda_int_ident
  import irda_iid_pkg::*;
#(
  parameter int TO_CHARS = 4
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       overrunErr,
  input  logic       parityErr,
  input  logic       stopErr,
  input  logic       breakDet,
  input  logic       rxDataReady,
  input  logic       fifoTrigHit,
  input  logic       rxNotEmpty,
  input  logic       charTick,
  input  logic       txEmpty,
  input  logic       fifoEn,
  input  logic       irqEn,
  input  logic       isrRead,
  input  logic       lsrRead,
  input  logic       rbrRead,
  input  logic       thrWrite,
  input  logic       rxPush,
  output logic [7:0] isrValue,
  output logic       irqOut
);

  iidStrobes_t strb;
  iidCode_e    curCode;

  irda_iid_ctrl u_ctrl (
    .isrRead (isrRead),
    .lsrRead (lsrRead),
    .rbrRead (rbrRead),
    .thrWrite(thrWrite),
    .rxPush  (rxPush),
    .curCode (curCode),
    .strb    (strb)
  );

  irda_iid_dp #(.TO_CHARS(TO_CHARS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .errPulse   ({overrunErr, parityErr, stopErr, breakDet}),
    .rxDataReady(rxDataReady),
    .fifoTrigHit(fifoTrigHit),
    .rxNotEmpty (rxNotEmpty),
    .charTick   (charTick),
    .txEmpty    (txEmpty),
    .fifoEn     (fifoEn),
    .strb       (strb),
    .curCode    (curCode),
    .isrValue   (isrValue)
  );

  assign irqOut = irqEn & ~isrValue[0];

endmodule

// File: rtl/irda_iid_checker.sv
module irda_iid_checker (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] errPulse,
  input logic       fifoEn,
  input logic       irqEn,
  input logic       txEmpty,
  input logic       isrRead,
  input logic       lsrRead,
  input logic       rbrRead,
  input logic [7:0] isrValue,
  input logic       irqOut
);

  // R1
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isrValue[5:4] == 2'b00) && (isrValue[7:6] == {fifoEn, fifoEn}));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (irqEn && !isrValue[0]));

  // R5
  tmo_fifo_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    isrValue[3] |-> fifoEn);

  // R3
  err_shows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|errPulse) |=> (isrValue[3:0] == 4'b0110));

  // R3
  lsr_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lsrRead && !(|errPulse)) |=> (isrValue[3:0] != 4'b0110));

  // R5
  rbr_clears_tmo_chk: assert property (@(posedge clk) disable iff (!rstN)
    rbrRead |=> (isrValue[3:0] != 4'b1100));

  // R8
  isr_ack_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isrRead && (isrValue[3:0] == 4'b0010) && txEmpty && $past(txEmpty))
    |=> (isrValue[3:0] != 4'b0010));

endmodule

bind irda_int_ident irda_iid_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .errPulse({overrunErr, parityErr, stopErr, breakDet}),
  .fifoEn  (fifoEn),
  .irqEn   (irqEn),
  .txEmpty (txEmpty),
  .isrRead (isrRead),
  .lsrRead (lsrRead),
  .rbrRead (rbrRead),
  .isrValue(isrValue),
  .irqOut  (irqOut)
);

// File: tb/tb_irda_int_ident.sv
module tb_irda_int_ident;

  localparam int CLK_PERIOD = 10;
  localparam int TO_CHARS   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic overrunErr = 0, parityErr = 0, stopErr = 0, breakDet = 0;
  logic rxDataReady = 0, fifoTrigHit = 0, rxNotEmpty = 0, charTick = 0;
  logic txEmpty = 1, fifoEn = 0, irqEn = 1;
  logic isrRead = 0, lsrRead = 0, rbrRead = 0, thrWrite = 0, rxPush = 0;
  logic [7:0] isrValue;
  logic irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  bit mRxs = 0, mTmo = 0, mTxd = 1, mThre = 0;
  int mCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irda_int_ident #(.TO_CHARS(TO_CHARS)) dut (.*);

  function automatic logic [3:0] expCode();
    logic rda;
    rda = fifoEn ? fifoTrigHit : rxDataReady;
    if (mRxs)               return 4'b0110;
    if (rda)                return 4'b0100;
    if (mTmo && fifoEn)     return 4'b1100;
    if (mThre)              return 4'b0010;
    return 4'b0001;
  endfunction

  function automatic logic [7:0] expIsr();
    return {fifoEn, fifoEn, 2'b00, expCode()};
  endfunction

  function automatic string tagOf(logic [3:0] c);
    case (c)
      4'b0110: return "R3";
      4'b0100: return "R4";
      4'b1100: return "R5";
      4'b0010: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    bit errs, idle, rst, rise, ackTx;
    logic [3:0] c;
    c     = expCode();
    errs  = overrunErr | parityErr | stopErr | breakDet;
    idle  = !fifoEn || !rxNotEmpty;
    rst   = rbrRead || rxPush;
    rise  = txEmpty && !mTxd;
    ackTx = thrWrite || (isrRead && c == 4'b0010);
    if (errs) mRxs = 1; else if (lsrRead) mRxs = 0;
    if (idle || rbrRead) mTmo = 0;
    else if (charTick && !rst && mCnt == TO_CHARS - 1) mTmo = 1;
    if (idle || rst) mCnt = 0;
    else if (charTick && mCnt != TO_CHARS) mCnt++;
    if (rise) mThre = 1; else if (ackTx) mThre = 0;
    mTxd = txEmpty;
  endtask

  // called just after a falling edge with inputs already set
  task automatic cyc();
    string t;
    #1;
    t = tagOf(expCode());
    chk(t, isrValue, expIsr());
    chk("R10", {7'd0, irqOut}, {7'd0, irqEn && expCode() != 4'b0001});
    modelStep();
    @(negedge clk);
    {overrunErr, parityErr, stopErr, breakDet} = 4'b0;
    {isrRead, lsrRead, rbrRead, thrWrite, rxPush} = 5'b0;
  endtask

  task automatic peek(string tag, logic [7:0] exp);
    #1;
    chk(tag, isrValue, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1143));
    repeat (3) @(negedge clk);
    // R2 reset state
    peek("R2", 8'h01);
    chk("R2", {7'd0, irqOut}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);
    peek("R2", 8'h01);

    // R3 error sets, line status read clears
    parityErr = 1; cyc(); peek("R3", 8'h06);
    cyc(); peek("R3", 8'h06);
    lsrRead = 1; cyc(); peek("R3", 8'h01);
    breakDet = 1; lsrRead = 1; cyc(); peek("R3", 8'h06);
    lsrRead = 1; cyc(); peek("R3", 8'h01);

    // R7 rising edge of tx empty
    txEmpty = 0; cyc(); peek("R7", 8'h01);
    txEmpty = 1; cyc(); peek("R7", 8'h02);
    // R9 / R8 hidden behind receive status
    stopErr = 1; cyc(); peek("R9", 8'h06);
    isrRead = 1; cyc(); peek("R8", 8'h06);
    lsrRead = 1; cyc(); peek("R9", 8'h02);
    isrRead = 1; cyc(); peek("R8", 8'h01);
    txEmpty = 0; cyc(); txEmpty = 1; cyc(); peek("R7", 8'h02);
    thrWrite = 1; cyc(); peek("R7", 8'h01);

    // R10 enable gate
    txEmpty = 0; cyc(); txEmpty = 1; cyc();
    irqEn = 0; #1; chk("R10", {7'd0, irqOut}, 8'd0);
    irqEn = 1; #1; chk("R10", {7'd0, irqOut}, 8'd1);
    thrWrite = 1; cyc();

    // R4 received data source
    rxDataReady = 1; cyc(); peek("R4", 8'h04);
    fifoEn = 1; #1; chk("R4", isrValue, 8'hC1);
    fifoTrigHit = 1; #1; chk("R4", isrValue, 8'hC4);
    fifoTrigHit = 0; fifoEn = 0; rxDataReady = 0; cyc();

    // R5 / R6 time-out
    fifoEn = 1; rxNotEmpty = 1; charTick = 1;
    cyc(); cyc(); cyc(); peek("R6", 8'hC1);
    rxPush = 1; cyc(); peek("R6", 8'hC1);
    cyc(); cyc(); cyc(); peek("R6", 8'hC1);
    cyc(); peek("R5", 8'hCC);
    rbrRead = 1; cyc(); peek("R5", 8'hC1);
    cyc(); cyc(); cyc(); cyc(); peek("R5", 8'hCC);
    fifoEn = 0; #1; chk("R5", isrValue, 8'h01);
    cyc(); fifoEn = 1; cyc(); peek("R5", 8'hC1);
    rxNotEmpty = 0; cyc(); cyc(); cyc(); cyc(); cyc(); peek("R6", 8'hC1);
    // R1 fixed bits
    fifoEn = 0; cyc(); peek("R1", 8'h01);
    charTick = 0;

    // constrained random run
    for (int i = 0; i < 4000; i++) begin
      overrunErr  = ($urandom % 64) == 0;
      parityErr   = ($urandom % 64) == 0;
      stopErr     = ($urandom % 96) == 0;
      breakDet    = ($urandom % 96) == 0;
      lsrRead     = ($urandom % 8) == 0;
      isrRead     = ($urandom % 4) == 0;
      rbrRead     = ($urandom % 12) == 0;
      rxPush      = ($urandom % 12) == 0;
      thrWrite    = ($urandom % 10) == 0;
      charTick    = ($urandom % 2) == 0;
      if (($urandom % 64) == 0) fifoEn = ~fifoEn;
      if (($urandom % 16) == 0) rxNotEmpty = ~rxNotEmpty;
      if (($urandom % 8) == 0)  txEmpty = ~txEmpty;
      if (($urandom % 10) == 0) rxDataReady = ~rxDataReady;
      if (($urandom % 10) == 0) fifoTrigHit = ~fifoTrigHit;
      if (($urandom % 32) == 0) irqEn = ~irqEn;
      cyc();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule